// File: doc/BRIEF.md
# Flash Operation Status Register

This block holds the status byte and error flags for a NOR-style flash program/erase controller, and contains a small pulse-and-verify sequencer. Upstream logic decodes bus cycles into single-cycle command strobes: program, block erase, blank check and clear status. The block decides whether each command may run. An accepted program or erase alternates a pulse cycle with a verify cycle until the array reports success or the pulse budget runs out. A blank check walks the words of the block and compares each word against all ones.

Three error flags are sticky: erase/blank-check, program and supply. Once a flag is set, every later command that depends on it is refused until software clears the flags while the controller is idle, or until a hardware reset. The supply level is looked at only in the cycle in which a program or erase is requested. A program that would turn a 0 cell back to 1 is reported as an error only when the high programming supply is present.

Top module: `flash_stat_ctl`

## Requirements
- R1: `status` has the ready bit at position 7: 1 when idle, 0 while an operation runs. Bit 5 is the erase/blank-check error, bit 4 the program error and bit 3 the supply error. Bits 6, 2, 1 and 0 always read 0. After reset `status` is 8'h80.
- R2: An accepted program or erase raises `op_accept` and clears bit 7 in the cycle after the strobe. It then repeats a one-cycle pulse (`pulse_on`=1) followed by one verify cycle. If `verify_pass` is high in the k-th verify cycle, bit 7 returns to 1 after exactly 2k busy cycles and no error flag is set.
- R3: An erase whose verify never passes stops after MAX_PULSES pulses (2*MAX_PULSES busy cycles) and sets bit 5.
- R4: A program whose verify never passes stops after MAX_PULSES pulses and sets bit 4.
- R5: A blank check issues no pulses and stays busy for BLK_WORDS cycles. It presents `scan_addr` = 0, 1, … BLK_WORDS-1, one per cycle, and sets bit 5 if any returned `scan_word` differs from all ones.
- R6: When a program or erase is requested, `vpp_ok` is sampled in the request cycle. If it is low, bit 3 is set, `op_reject` pulses and no pulse is issued. Changes of `vpp_ok` during a running operation have no effect.
- R7: A program whose `prog_data` has a 1 where `cell_data` has a 0 is refused and sets bit 4 when `vpp_high` is 1. When `vpp_high` is 0 it runs as a normal program and flags nothing at the start.
- R8: Bits 5, 4 and 3, once set, stay set until a clear strobe is seen while idle, or until reset.
- R9: An erase is refused if bit 5 or bit 3 is set. A program is refused if bit 4 or bit 3 is set. A blank check is refused if bit 5 is set. A refusal pulses `op_reject` in the next cycle, keeps bit 7 at 1, issues no pulse and leaves the flags unchanged.
- R10: While busy, all command strobes, including clear, are ignored.
- R11: When several strobes arrive together while idle, only the highest-priority one acts. The order is clear, then erase, then blank check, then program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cmd_prog | input | 1 | Program request strobe |
| cmd_erase | input | 1 | Block erase request strobe |
| cmd_blank | input | 1 | Blank check request strobe |
| cmd_clear | input | 1 | Clear error flags strobe |
| vpp_ok | input | 1 | Supply above lockout level |
| vpp_high | input | 1 | Supply at high programming level |
| prog_data | input | WORD_W | Word to be programmed |
| cell_data | input | WORD_W | Current content of the target word |
| verify_pass | input | 1 | Array verify result, read in verify cycles |
| scan_word | input | WORD_W | Array word at `scan_addr` during blank check |
| status | output | 8 | Status byte |
| op_accept | output | 1 | One-cycle pulse: command started |
| op_reject | output | 1 | One-cycle pulse: command refused |
| pulse_on | output | 1 | Program/erase pulse active |
| scan_addr | output | max(1,clog2(BLK_WORDS)) | Word index during blank check |

## Verification
The bench sweeps the verify-success point from the first pulse to never, for both program and erase. A design with an off-by-one pulse limit shows up as a wrong busy length, a wrong pulse count, or a flag set on the last allowed pass. Blank check is run with a bad word at every index, so an address walk that skips or repeats a word, or that drops the final word's compare, misses one of the errors. All eight combinations of the three flags are crossed with the three commands. A wrong refusal rule therefore starts or blocks the wrong operation. Priority between simultaneous strobes, a clear strobe issued mid-operation, and a supply drop mid-operation are exercised. A design that honoured any of these would lose or corrupt a flag.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PULSE  = 2'd1,
      ST_VERIFY = 2'd2,
      ST_SCAN   = 2'd3
   } seq_st_e;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_BLANK = 2'd3
   } op_e;

   // positions in the status byte (decoded by software)
   localparam int SB_READY  = 7;
   localparam int SB_ERASE  = 5;
   localparam int SB_PROG   = 4;
   localparam int SB_SUPPLY = 3;

   // index into the sticky flag vector
   localparam int FL_SUPPLY = 0;
   localparam int FL_PROG   = 1;
   localparam int FL_ERASE  = 2;
   localparam int FL_N      = 3;

endpackage

// File: rtl/fsr_seq.sv
module fsr_seq
   import fsr_pkg::*;
#(
   parameter int MAX_PULSES = 8,
   parameter int WORD_W     = 16,
   parameter int BLK_WORDS  = 8,
   localparam int CNT_W = (MAX_PULSES > 1) ? $clog2(MAX_PULSES) : 1,
   localparam int AW    = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               launch_op,
   input  logic              verify_pass,
   input  logic [WORD_W-1:0] scan_word,
   output logic              idle,
   output logic              pulse_on,
   output logic [AW-1:0]     scan_addr,
   output logic              fail_erase,
   output logic              fail_prog
);

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_PULSES - 1);
   localparam logic [AW-1:0]    LAST_IDX = AW'(BLK_WORDS - 1);

   seq_st_e           st_q;
   op_e               kind_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [AW-1:0]     idx_q;
   logic              bad_q;
   logic              word_bad;
   logic              budget_out;
   logic              scan_end;

   assign word_bad   = (scan_word != {WORD_W{1'b1}});
   assign budget_out = (st_q == ST_VERIFY) && !verify_pass && (cnt_q == LAST_CNT);
   assign scan_end   = (st_q == ST_SCAN) && (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= OP_NONE;
         cnt_q  <= '0;
         idx_q  <= '0;
         bad_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               unique case (launch_op)
                  OP_PROG, OP_ERASE: begin
                     st_q   <= ST_PULSE;
                     kind_q <= launch_op;
                     cnt_q  <= '0;
                  end
                  OP_BLANK: begin
                     st_q   <= ST_SCAN;
                     kind_q <= OP_BLANK;
                     idx_q  <= '0;
                     bad_q  <= 1'b0;
                  end
                  default: ;
               endcase
            end
            ST_PULSE: st_q <= ST_VERIFY;
            ST_VERIFY: begin
               if (verify_pass || cnt_q == LAST_CNT) begin
                  st_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
                  st_q  <= ST_PULSE;
               end
            end
            ST_SCAN: begin
               bad_q <= bad_q | word_bad;
               if (idx_q == LAST_IDX) st_q <= ST_IDLE;
               else                   idx_q <= idx_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idle       = (st_q == ST_IDLE);
   assign pulse_on   = (st_q == ST_PULSE);
   assign scan_addr  = idx_q;
   assign fail_prog  = budget_out && (kind_q == OP_PROG);
   assign fail_erase = (budget_out && (kind_q == OP_ERASE)) ||
                       (scan_end && (bad_q || word_bad));

endmodule

// File: rtl/fsr_flags.sv
module fsr_flags
   import fsr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_clear,
   input  logic            req_erase,
   input  logic            req_blank,
   input  logic            req_prog,
   input  logic            vpp_ok,
   input  logic            vpp_high,
   input  logic            overprog,
   input  logic            fail_erase,
   input  logic            fail_prog,
   output logic [FL_N-1:0] flags,
   output op_e             launch_op,
   output logic            reject
);

   logic            stale_e, stale_p, stale_b;
   logic            go_e, go_p, go_b;
   logic            ovp_hit;
   logic [FL_N-1:0] set_v;

   assign stale_e = flags[FL_ERASE] | flags[FL_SUPPLY];
   assign stale_p = flags[FL_PROG]  | flags[FL_SUPPLY];
   assign stale_b = flags[FL_ERASE];
   assign ovp_hit = vpp_high & overprog;

   assign go_e = req_erase & !stale_e & vpp_ok;
   assign go_p = req_prog  & !stale_p & vpp_ok & !ovp_hit;
   assign go_b = req_blank & !stale_b;

   always_comb begin
      launch_op = OP_NONE;
      if (go_e)      launch_op = OP_ERASE;
      else if (go_b) launch_op = OP_BLANK;
      else if (go_p) launch_op = OP_PROG;
   end

   assign reject = (req_erase & (stale_e | !vpp_ok)) |
                   (req_prog  & (stale_p | !vpp_ok | ovp_hit)) |
                   (req_blank & stale_b);

   assign set_v[FL_SUPPLY] = ((req_erase & !stale_e) | (req_prog & !stale_p)) & !vpp_ok;
   assign set_v[FL_PROG]   = (req_prog & !stale_p & vpp_ok & ovp_hit) | fail_prog;
   assign set_v[FL_ERASE]  = fail_erase;

   for (genvar g = 0; g < FL_N; g++) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         flags[g] <= 1'b0;
         else if (req_clear) flags[g] <= 1'b0;
         else if (set_v[g])  flags[g] <= 1'b1;
      end
   end

endmodule

// File: rtl/flash_stat_ctl.sv
module flash_stat_ctl
   import fsr_pkg::*;
#(
   parameter int MAX_PULSES = 8,
   parameter int WORD_W     = 16,
   parameter int BLK_WORDS  = 8,
   localparam int AW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_prog,
   input  logic              cmd_erase,
   input  logic              cmd_blank,
   input  logic              cmd_clear,
   input  logic              vpp_ok,
   input  logic              vpp_high,
   input  logic [WORD_W-1:0] prog_data,
   input  logic [WORD_W-1:0] cell_data,
   input  logic              verify_pass,
   input  logic [WORD_W-1:0] scan_word,
   output logic [7:0]        status,
   output logic              op_accept,
   output logic              op_reject,
   output logic              pulse_on,
   output logic [AW-1:0]     scan_addr
);

   if (MAX_PULSES < 1) begin : g_bad_pulses
      $error("MAX_PULSES must be at least 1");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("WORD_W must be at least 1");
   end
   if (BLK_WORDS < 1) begin : g_bad_words
      $error("BLK_WORDS must be at least 1");
   end

   logic            idle;
   logic            req_clear, req_erase, req_blank, req_prog;
   logic            overprog;
   logic            fail_erase, fail_prog;
   logic            reject;
   op_e             launch_op;
   logic [FL_N-1:0] flags;

   // fixed priority among simultaneous strobes, only while idle
   assign req_clear = idle & cmd_clear;
   assign req_erase = idle & !cmd_clear & cmd_erase;
   assign req_blank = idle & !cmd_clear & !cmd_erase & cmd_blank;
   assign req_prog  = idle & !cmd_clear & !cmd_erase & !cmd_blank & cmd_prog;

   // a 1 requested on a cell that already holds 0
   assign overprog = |(prog_data & ~cell_data);

   fsr_flags flags_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_clear  (req_clear),
      .req_erase  (req_erase),
      .req_blank  (req_blank),
      .req_prog   (req_prog),
      .vpp_ok     (vpp_ok),
      .vpp_high   (vpp_high),
      .overprog   (overprog),
      .fail_erase (fail_erase),
      .fail_prog  (fail_prog),
      .flags      (flags),
      .launch_op  (launch_op),
      .reject     (reject)
   );

   fsr_seq #(
      .MAX_PULSES (MAX_PULSES),
      .WORD_W     (WORD_W),
      .BLK_WORDS  (BLK_WORDS)
   ) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch_op   (launch_op),
      .verify_pass (verify_pass),
      .scan_word   (scan_word),
      .idle        (idle),
      .pulse_on    (pulse_on),
      .scan_addr   (scan_addr),
      .fail_erase  (fail_erase),
      .fail_prog   (fail_prog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_accept <= 1'b0;
         op_reject <= 1'b0;
      end else begin
         op_accept <= (launch_op != OP_NONE);
         op_reject <= reject;
      end
   end

   always_comb begin
      status             = 8'h00;
      status[SB_READY]   = idle;
      status[SB_ERASE]   = flags[FL_ERASE];
      status[SB_PROG]    = flags[FL_PROG];
      status[SB_SUPPLY]  = flags[FL_SUPPLY];
   end

endmodule

// File: rtl/fsr_chk.sv
module fsr_chk #(
   parameter int MAX_PULSES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_prog,
   input logic       cmd_erase,
   input logic       cmd_blank,
   input logic       cmd_clear,
   input logic       op_accept,
   input logic       op_reject,
   input logic       pulse_on,
   input logic [7:0] status
);

   int unsigned pulses_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pulses_seen <= 0;
      else if (op_accept) pulses_seen <= pulse_on ? 1 : 0;
      else if (pulse_on)  pulses_seen <= pulses_seen + 1;
   end

   // R2
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_accept |-> !status[7]);

   // R2
   pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_on |-> !status[7]);

   // R3
   pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulses_seen <= MAX_PULSES);

   // R9
   accept_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_accept && op_reject));

   // R9
   stale_erase_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && cmd_erase && !cmd_clear && (status[5] || status[3]))
      |=> (op_reject && status[7]));

   // R9
   stale_prog_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && cmd_prog && !cmd_clear && !cmd_erase && !cmd_blank &&
       (status[4] || status[3])) |=> (op_reject && status[7]));

   // R8
   erase_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[5]) |-> ($past(cmd_clear) && $past(status[7])));

   // R8
   prog_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[4]) |-> ($past(cmd_clear) && $past(status[7])));

   // R8
   supply_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[3]) |-> ($past(cmd_clear) && $past(status[7])));

endmodule

bind flash_stat_ctl fsr_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_prog  (cmd_prog),
   .cmd_erase (cmd_erase),
   .cmd_blank (cmd_blank),
   .cmd_clear (cmd_clear),
   .op_accept (op_accept),
   .op_reject (op_reject),
   .pulse_on  (pulse_on),
   .status    (status)
);

// File: tb/flash_stat_ctl_tb.sv
module flash_stat_ctl_tb_top;

   localparam int MP = 3;
   localparam int NW = 4;
   localparam int W  = 16;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_prog = 0, cmd_erase = 0, cmd_blank = 0, cmd_clear = 0;
   logic          vpp_ok = 1, vpp_high = 0;
   logic [W-1:0]  prog_data = '0, cell_data = '0;
   logic          verify_pass;
   logic [W-1:0]  scan_word;
   logic [7:0]    status;
   logic          op_accept, op_reject, pulse_on;
   logic [AW-1:0] scan_addr;

   logic [W-1:0]  blk [NW];
   int            pass_at = 1;
   int            pcnt = 0;
   logic          pclr = 0;
   int            checks = 0, errors = 0;
   int            r_acc, r_rej, r_busy, r_pulses;

   always #10 clk = ~clk;

   always @(posedge clk) pcnt <= pclr ? 0 : pcnt + (pulse_on ? 1 : 0);

   assign verify_pass = (pass_at != 0) && (pcnt >= pass_at);
   assign scan_word   = blk[scan_addr];

   flash_stat_ctl #(.MAX_PULSES(MP), .WORD_W(W), .BLK_WORDS(NW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_blank(cmd_blank), .cmd_clear(cmd_clear),
      .vpp_ok(vpp_ok), .vpp_high(vpp_high), .prog_data(prog_data), .cell_data(cell_data),
      .verify_pass(verify_pass), .scan_word(scan_word),
      .status(status), .op_accept(op_accept), .op_reject(op_reject),
      .pulse_on(pulse_on), .scan_addr(scan_addr)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // mask bits: 0 program, 1 erase, 2 blank, 3 clear
   task automatic start(input logic [3:0] m);
      cmd_prog = m[0]; cmd_erase = m[1]; cmd_blank = m[2]; cmd_clear = m[3];
      pclr = 1;
      @(negedge clk);
      cmd_prog = 0; cmd_erase = 0; cmd_blank = 0; cmd_clear = 0;
      pclr = 0;
      r_acc = int'(op_accept);
      r_rej = int'(op_reject);
   endtask

   task automatic wait_idle();
      r_busy = 0;
      while (!status[7] && r_busy < 500) begin
         r_busy++;
         @(negedge clk);
      end
      r_pulses = pcnt;
   endtask

   task automatic issue(input logic [3:0] m);
      start(m);
      wait_idle();
   endtask

   task automatic quiet();
      vpp_ok = 1; vpp_high = 0; prog_data = '0; cell_data = '0; pass_at = 1;
      for (int i = 0; i < NW; i++) blk[i] = '1;
   endtask

   // fl bits: 2 erase flag, 1 program flag, 0 supply flag
   task automatic set_flags(input logic [2:0] fl);
      quiet();
      issue(4'b1000);
      if (fl[1]) begin
         vpp_high = 1; prog_data = 16'h0001; cell_data = 16'h0000;
         issue(4'b0001);
         quiet();
      end
      if (fl[0]) begin
         vpp_ok = 0;
         issue(4'b0010);
         quiet();
      end
      if (fl[2]) begin
         blk[0] = 16'h0000;
         issue(4'b0100);
         quiet();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      quiet();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset status", int'(status), 'h80);
      chk("R1 reset accept", int'(op_accept), 0);
      chk("R1 reset pulse", int'(pulse_on), 0);

      // pulse budget sweep for program and erase
      for (int k = 0; k < 2; k++) begin
         for (int pa = 0; pa <= MP; pa++) begin
            quiet();
            issue(4'b1000);
            pass_at = pa;
            issue(k == 0 ? 4'b0001 : 4'b0010);
            chk("R2 accept", r_acc, 1);
            chk(pa == 0 ? "R3 R4 busy at budget" : "R2 busy cycles", r_busy, pa == 0 ? 2*MP : 2*pa);
            chk(pa == 0 ? "R3 R4 pulses at budget" : "R2 pulse count", r_pulses, pa == 0 ? MP : pa);
            if (k == 0) chk("R4 program flag", int'(status[4]), pa == 0 ? 1 : 0);
            else        chk("R3 erase flag", int'(status[5]), pa == 0 ? 1 : 0);
            chk("R1 reserved bits", int'({status[6], status[2:0]}), 0);
         end
      end

      // blank check with a bad word at each index, and none
      for (int bad = -1; bad < NW; bad++) begin
         quiet();
         issue(4'b1000);
         if (bad >= 0) blk[bad] = (bad % 2 == 0) ? 16'hFFFE : 16'h7FFF;
         issue(4'b0100);
         chk("R5 blank accept", r_acc, 1);
         chk("R5 blank busy", r_busy, NW);
         chk("R5 blank no pulses", r_pulses, 0);
         chk("R5 blank flag", int'(status[5]), bad >= 0 ? 1 : 0);
      end

      // flag combinations crossed with commands
      for (int fl = 0; fl < 8; fl++) begin
         for (int c = 0; c < 3; c++) begin
            logic exp_rej;
            set_flags(3'(fl));
            chk("R8 flags held", int'(status[5:3]), fl);
            case (c)
               0: exp_rej = fl[1] | fl[0];
               1: exp_rej = fl[2] | fl[0];
               default: exp_rej = fl[2];
            endcase
            issue(c == 0 ? 4'b0001 : c == 1 ? 4'b0010 : 4'b0100);
            chk("R9 reject", r_rej, int'(exp_rej));
            chk("R9 accept", r_acc, int'(!exp_rej));
            chk("R9 busy", r_busy, exp_rej ? 0 : (c == 2 ? NW : 2));
            chk("R9 flags unchanged", int'(status[5:3]), fl);
         end
      end

      // supply low at request
      for (int c = 0; c < 2; c++) begin
         quiet();
         issue(4'b1000);
         vpp_ok = 0;
         issue(c == 0 ? 4'b0001 : 4'b0010);
         chk("R6 low supply reject", r_rej, 1);
         chk("R6 low supply no pulse", r_pulses, 0);
         chk("R6 supply flag", int'(status), 'h88);
      end

      // supply drop during operation
      quiet();
      issue(4'b1000);
      pass_at = 2;
      start(4'b0010);
      vpp_ok = 0;
      wait_idle();
      chk("R6 mid-op supply ignored", int'(status), 'h80);
      chk("R6 mid-op pulses", r_pulses, 2);

      // overprogram at low and high programming supply
      quiet();
      issue(4'b1000);
      prog_data = 16'h8000; cell_data = 16'h0000; vpp_high = 0;
      issue(4'b0001);
      chk("R7 overprogram low supply accepted", r_acc, 1);
      chk("R7 overprogram low supply flag", int'(status), 'h80);
      vpp_high = 1;
      issue(4'b0001);
      chk("R7 overprogram high supply reject", r_rej, 1);
      chk("R7 overprogram high supply flag", int'(status), 'h90);

      // clear and other strobes while busy
      set_flags(3'b010);
      pass_at = 2;
      start(4'b0010);
      cmd_clear = 1; cmd_prog = 1;
      @(negedge clk);
      cmd_clear = 0; cmd_prog = 0;
      wait_idle();
      chk("R10 clear while busy ignored", int'(status), 'h90);
      chk("R10 strobes while busy ignored", r_pulses, 2);
      issue(4'b1000);
      chk("R8 clear when idle", int'(status), 'h80);

      // priority
      quiet();
      issue(4'b1000);
      vpp_high = 1; prog_data = 16'h0001; cell_data = 16'h0000; pass_at = 1;
      issue(4'b0011);
      chk("R11 erase over program", r_acc, 1);
      chk("R11 erase over program flags", int'(status), 'h80);
      quiet();
      issue(4'b0101);
      chk("R11 blank over program busy", r_busy, NW);
      chk("R11 blank over program pulses", r_pulses, 0);
      issue(4'b0110);
      chk("R11 erase over blank pulses", r_pulses, 1);
      set_flags(3'b111);
      issue(4'b1111);
      chk("R11 clear first accept", r_acc + r_rej, 0);
      chk("R11 clear first status", int'(status), 'h80);

      // hardware reset clears flags
      set_flags(3'b111);
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R8 reset clears flags", int'(status), 'h80);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule